// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into register sets of 32. Each set holds a direction mask and an output latch. Software changes the output latch either by writing it directly or by writing bit masks to a set-high register and a set-low register. Each pin's input is passed through a two-flop synchroniser. The synchronised level can always be read back, including on pins that are driving.

Every pin can flag a rising edge, a falling edge, or both. Each edge enable has its own write-one-to-set and write-one-to-clear register. Enabled edges latch into a per-set status register that software clears by writing ones.

Each 32-pin set drives two interrupt lines, one for its lower 16 pins and one for its upper 16 pins. A global half-bank enable register gates each line. The lowest pins can also present a direct one-cycle interrupt pulse per pin, for a controller that wants each pin on its own line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After synchronous reset, every pin is an input (direction reads all ones, `pin_oe` is all zero). The output latch, edge enables, status, half-bank enables and all interrupt outputs are zero.
- R2: Set k decodes offsets relative to its base. The layout is: direction +0x00, output latch +0x04, set-high +0x08, set-low +0x0C, input level +0x10, rising enable set/clear +0x14/+0x18, falling enable set/clear +0x1C/+0x20, status +0x24. Writing a mask to set-high drives those output bits to 1, and writing a mask to set-low drives them to 0. Unmasked bits keep their value, and the output latch reads back the result.
- R3: The direction register is read/write, with 1 meaning input. `pin_oe[n]` is the inverse of direction bit n.
- R4: Reading the input-level register returns `pin_in` after a two-flop synchroniser. A read issued in the same cycle as a pin change returns the old level. Writes to the input-level register are ignored.
- R5: A 0-to-1 transition of a synchronised pin with its rising enable set sets that pin's status bit. A 1-to-0 transition does not set it unless the falling enable is set.
- R6: A 1-to-0 transition sets the status bit when the falling enable is set. With both enables set, either edge sets the bit.
- R7: Writing ones to an enable's set or clear register sets or clears only those enable bits. Reading either register returns the current enable mask.
- R8: Writing ones to the status register clears those bits and leaves the others. If a new edge hits a bit in the same cycle as its clear, the bit stays set.
- R9: The half-bank enable register is at 0x08, with bit h for half-bank h. Half-bank h covers bits 16*(h%2) to 16*(h%2)+15 of set h/2. `bank_irq[h]` is high one cycle after both enable bit h and any of its 16 status bits are set.
- R10: Set k sits at byte address 0x10 + 0x28*k. Pin n belongs to set n/32 at bit n%32. Unmapped addresses read as zero, and read data appears one cycle after the address.
- R11: For pins below `DIRECT_IRQS`, `pin_irq[n]` pulses high for one cycle per enabled edge detected on pin n. The half-bank enables do not gate it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after address |
| pin_in | input | 32*NUM_SETS | Pin input levels |
| pin_out | output | 32*NUM_SETS | Output latch |
| pin_oe | output | 32*NUM_SETS | Output enable, 1 drives |
| bank_irq | output | 2*NUM_SETS | Half-bank interrupt lines |
| pin_irq | output | DIRECT_IRQS | Direct per-pin edge pulses |

## Verification
Edge detection is exercised with single rises, single falls, and both-edge pins. This separates the rising and falling enables and shows that an unenabled edge leaves no trace. Reads of the input-level register in the same cycle as a pin change, and again two cycles later, separate synchroniser latency from a wrong value. A clear timed to land on the same edge as a new event separates set-priority from clear-priority. Masks on two different sets and both halves of a set confirm the address map and the half-bank grouping.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [7:0] HB_EN_ADDR = 8'h08;
  localparam int         SET_BASE0  = 16;
  localparam int         SET_STRIDE = 40;

  typedef enum logic [5:0] {
    RG_DIR  = 6'h00,
    RG_OUT  = 6'h04,
    RG_HIGH = 6'h08,
    RG_LOW  = 6'h0C,
    RG_LVL  = 6'h10,
    RG_RSET = 6'h14,
    RG_RCLR = 6'h18,
    RG_FSET = 6'h1C,
    RG_FCLR = 6'h20,
    RG_STAT = 6'h24
  } gpio_reg_e;

  function automatic int set_base(input int k);
    return SET_BASE0 + SET_STRIDE * k;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta  <= '0;
      lvl   <= '0;
      lvl_d <= '0;
    end else begin
      meta  <= raw;
      lvl   <= meta;
      lvl_d <= lvl;
    end
  end
endmodule

// File: rtl/gpio_reg_set.sv
module gpio_reg_set
  import gpio_bank_pkg::*;
#(
  parameter int BASE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic [31:0] lvl,
  input  logic [31:0] lvl_d,
  output logic [31:0] out_q,
  output logic [31:0] dir_q,
  output logic [31:0] stat_q,
  output logic [31:0] evt,
  output logic        rd_hit,
  output logic [31:0] rd_data
);
  localparam logic [8:0] LO    = 9'(BASE);
  localparam logic [8:0] HI    = 9'(BASE + SET_STRIDE);
  localparam logic [7:0] BASE8 = 8'(BASE);

  logic [31:0] rise_en, fall_en, stat_clr;
  logic [7:0]  offs;
  logic [5:0]  idx;
  logic        hit, wr_hit;

  assign offs   = addr - BASE8;
  assign idx    = offs[5:0];
  assign hit    = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI) && (addr[1:0] == 2'b00);
  assign wr_hit = wr_en && hit;

  // edge events gated by the per-pin enables
  assign evt = (lvl & ~lvl_d & rise_en) | (~lvl & lvl_d & fall_en);

  assign stat_clr = (wr_hit && idx == RG_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '1;
      out_q   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      stat_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | evt;
      if (wr_hit) begin
        case (idx)
          RG_DIR:  dir_q   <= wdata;
          RG_OUT:  out_q   <= wdata;
          RG_HIGH: out_q   <= out_q | wdata;
          RG_LOW:  out_q   <= out_q & ~wdata;
          RG_RSET: rise_en <= rise_en | wdata;
          RG_RCLR: rise_en <= rise_en & ~wdata;
          RG_FSET: fall_en <= fall_en | wdata;
          RG_FCLR: fall_en <= fall_en & ~wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_hit = hit;
    case (idx)
      RG_DIR:           rd_data = dir_q;
      RG_OUT, RG_HIGH,
      RG_LOW:           rd_data = out_q;
      RG_LVL:           rd_data = lvl;
      RG_RSET, RG_RCLR: rd_data = rise_en;
      RG_FSET, RG_FCLR: rd_data = fall_en;
      RG_STAT:          rd_data = stat_q;
      default:          rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int DIRECT_IRQS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic [7:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [32*NUM_SETS-1:0]   pin_in,
  output logic [32*NUM_SETS-1:0]   pin_out,
  output logic [32*NUM_SETS-1:0]   pin_oe,
  output logic [2*NUM_SETS-1:0]    bank_irq,
  output logic [DIRECT_IRQS-1:0]   pin_irq
);
  localparam int PINS   = 32 * NUM_SETS;
  localparam int HALVES = 2 * NUM_SETS;

  logic [PINS-1:0]   lvl, lvl_d, out_all, dir_all, irq_status, edge_evt;
  logic [HALVES-1:0] hb_en;
  logic [31:0]       set_rd [NUM_SETS];
  logic [NUM_SETS-1:0] set_hit;
  logic [31:0]       rd_mux, hb_rd;

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw   (pin_in),
    .lvl   (lvl),
    .lvl_d (lvl_d)
  );

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    gpio_reg_set #(.BASE(set_base(k))) u_set (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .lvl     (lvl[32*k +: 32]),
      .lvl_d   (lvl_d[32*k +: 32]),
      .out_q   (out_all[32*k +: 32]),
      .dir_q   (dir_all[32*k +: 32]),
      .stat_q  (irq_status[32*k +: 32]),
      .evt     (edge_evt[32*k +: 32]),
      .rd_hit  (set_hit[k]),
      .rd_data (set_rd[k])
    );
  end

  assign pin_out = out_all;
  assign pin_oe  = ~dir_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_en <= '0;
    end else if (reg_we && reg_addr == HB_EN_ADDR) begin
      hb_en <= reg_wdata[HALVES-1:0];
    end
  end

  always_comb begin
    hb_rd = '0;
    hb_rd[HALVES-1:0] = hb_en;
    rd_mux = '0;
    if (reg_addr == HB_EN_ADDR) begin
      rd_mux = hb_rd;
    end else begin
      for (int k = 0; k < NUM_SETS; k++) begin
        if (set_hit[k]) rd_mux = rd_mux | set_rd[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) bank_irq[h] <= 1'b0;
      else     bank_irq[h] <= hb_en[h] & (|irq_status[16*h +: 16]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_irq <= '0;
    else     pin_irq <= edge_evt[DIRECT_IRQS-1:0];
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_SETS    = 2,
  parameter int DIRECT_IRQS = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_we,
  input logic [7:0]              reg_addr,
  input logic [31:0]             reg_wdata,
  input logic [32*NUM_SETS-1:0]  pin_out,
  input logic [32*NUM_SETS-1:0]  pin_oe,
  input logic [2*NUM_SETS-1:0]   bank_irq,
  input logic [DIRECT_IRQS-1:0]  pin_irq,
  input logic [2*NUM_SETS-1:0]   hb_en,
  input logic [32*NUM_SETS-1:0]  irq_status,
  input logic [32*NUM_SETS-1:0]  edge_evt
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && bank_irq == '0 && pin_irq == '0 && irq_status == '0));

  // R2
  set_high_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_we && reg_addr == 8'h18) |-> ((pin_out[31:0] & $past(reg_wdata)) == $past(reg_wdata)));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(edge_evt) & ~irq_status) == '0));

  // R9
  half_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((bank_irq & ~$past(hb_en)) == '0));

  // R11
  direct_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ((pin_irq & ~irq_status[DIRECT_IRQS-1:0]) == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_SETS    (NUM_SETS),
  .DIRECT_IRQS (DIRECT_IRQS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .bank_irq   (bank_irq),
  .pin_irq    (pin_irq),
  .hb_en      (hb_en),
  .irq_status (irq_status),
  .edge_evt   (edge_evt)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic [3:0]  bank_irq;
  logic [7:0]  pin_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int pulse_cnt = 0;
  logic rd_req = 1'b0;
  logic pend = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NUM_SETS(2), .DIRECT_IRQS(8)) u0 (
    .clk (clk), .rst (rst), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .pin_in (pin_in),
    .pin_out (pin_out), .pin_oe (pin_oe), .bank_irq (bank_irq), .pin_irq (pin_irq)
  );

  // scoreboard monitor
  always @(posedge clk) pend <= rd_req;
  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (reg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
      end
    end
  end

  always @(negedge clk) if (!rst && pin_irq[2]) pulse_cnt++;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    rd_req = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(pin_oe, 64'h0, "R1 pin_oe");
    chk(pin_out, 64'h0, "R1 pin_out");
    chk({56'h0, pin_irq, bank_irq}, 64'h0, "R1 irq outputs");
    rd(8'h10, 32'hFFFF_FFFF, "R1 direction");
    rd(8'h5C, 32'h0, "R1 status");
    rd(8'h08, 32'h0, "R1 half enables");
    rd(8'h00, 32'h0, "R10 unmapped");

    // R2 set-high / set-low masks
    wr(8'h18, 32'h0000_00F0);
    rd(8'h14, 32'h0000_00F0, "R2 set-high");
    wr(8'h1C, 32'h0000_0030);
    rd(8'h14, 32'h0000_00C0, "R2 set-low");
    wr(8'h40, 32'h8000_0001);
    chk(pin_out, 64'h8000_0001_0000_00C0, "R10 set1 mapping");

    // R3 direction
    wr(8'h10, 32'hFFFF_FF0F);
    chk(pin_oe, 64'h0000_0000_0000_00F0, "R3 pin_oe");
    rd(8'h10, 32'hFFFF_FF0F, "R3 direction readback");

    // R4 synchronised input level
    pin_in = 64'h0000_1234_0000_0F5A;
    rd(8'h20, 32'h0, "R4 stale read");
    idle(2);
    rd(8'h20, 32'h0000_0F5A, "R4 level set0");
    rd(8'h48, 32'h0000_1234, "R4 level set1");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0000_0F5A, "R4 write ignored");
    pin_in = '0;
    idle(4);
    rd(8'h34, 32'h0, "R5 no enables no status");

    // R5/R6/R7 edge enables
    wr(8'h24, 32'h0000_0008);
    wr(8'h2C, 32'h0010_0000);
    pin_in[3] = 1'b1;
    idle(4);
    rd(8'h34, 32'h0000_0008, "R5 rising latched");
    pin_in[20] = 1'b1;
    idle(4);
    rd(8'h34, 32'h0000_0008, "R6 rise ignored on falling-only");
    pin_in[20] = 1'b0;
    idle(4);
    rd(8'h34, 32'h0010_0008, "R6 falling latched");
    rd(8'h28, 32'h0000_0008, "R7 rising enable readback");
    rd(8'h30, 32'h0010_0000, "R7 falling enable readback");

    // R9 half-bank gating
    chk({60'h0, bank_irq}, 64'h0, "R9 gated off");
    wr(8'h08, 32'h3);
    idle(2);
    chk({60'h0, bank_irq}, 64'h3, "R9 both halves");
    // R8 write-one-to-clear
    wr(8'h34, 32'h0000_0008);
    idle(2);
    chk({60'h0, bank_irq}, 64'h2, "R9 lower half cleared");
    rd(8'h34, 32'h0010_0000, "R8 partial clear");
    wr(8'h34, 32'h0010_0000);
    idle(2);
    chk({60'h0, bank_irq}, 64'h0, "R9 all cleared");

    // R7 clearing an enable
    wr(8'h28, 32'h0000_0008);
    pin_in[3] = 1'b0;
    idle(4);
    pin_in[3] = 1'b1;
    idle(4);
    rd(8'h34, 32'h0, "R7 rising disabled");

    // R6 both edges on pin 33
    wr(8'h4C, 32'h0000_0002);
    wr(8'h54, 32'h0000_0002);
    wr(8'h08, 32'h4);
    pin_in[33] = 1'b1;
    idle(4);
    rd(8'h5C, 32'h0000_0002, "R6 both rise");
    chk({60'h0, bank_irq}, 64'h4, "R9 set1 lower half");
    wr(8'h5C, 32'h0000_0002);
    idle(1);
    rd(8'h5C, 32'h0, "R8 cleared");
    pin_in[33] = 1'b0;
    idle(4);
    rd(8'h5C, 32'h0000_0002, "R6 both fall");

    // R8 clear collides with a new edge: event wins
    pin_in[33] = 1'b1;
    idle(2);
    wr(8'h5C, 32'h0000_0002);
    idle(1);
    rd(8'h5C, 32'h0000_0002, "R8 event wins over clear");

    // R11 direct pulse, independent of half enables
    wr(8'h08, 32'h0);
    pulse_cnt = 0;
    wr(8'h24, 32'h0000_0004);
    pin_in[2] = 1'b1;
    idle(6);
    chk(64'(pulse_cnt), 64'd1, "R11 single pulse");
    chk({60'h0, bank_irq}, 64'h0, "R11 half lines stay off");
    pin_in[2] = 1'b0;
    idle(6);
    chk(64'(pulse_cnt), 64'd1, "R11 no pulse on disabled fall");

    idle(2);
    summary();
  end
endmodule